// File: doc/BRIEF.md
# Hybrid-Coherence Last-Level Cache Controller

This block is the shared last-level cache controller for a group of devices that each follow their own coherence style. All devices send requests through a single request channel. A request carries an opcode, the requesting device's ID, a line address, a per-word mask and per-word write data or operands. The block keeps the line data itself, and the stored lines are treated as the whole memory. Ownership is tracked one word at a time in a directory, where each word holds an owned flag and an owner ID. Each line also keeps a sharer vector, one bit per device, which records the devices that read that line in writer-invalidate style.

The block accepts one request at a time. For each request it first sends an invalidation to every sharer it must notify. It then sends one forward message to each other device that owns a word the request touches. It finishes with exactly one response beat that carries the requester's ID and either data or a plain acknowledgement. The data and the directory are updated in the cycle that the response beat is presented. Self-invalidating reads, writer-invalidating reads, write-through writes, atomic fetch-and-add and word-granular ownership can all be used on the same line.

Top module: `hyb_llc_ctrl`

## Requirements
- R1: After reset, `req_ready_o` is high and no output valid is asserted. Every stored word reads zero, no word is owned and no line has sharers.
- R2: Opcode codes are 0 = self-invalidating read, 1 = shared read, 2 = write-through, 3 = take ownership, 4 = fetch-and-add, 5 = take ownership with data, 6 = write-back. A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both high, and `req_ready_o` is high only when no request is in progress. After acceptance the block emits a gap-free run of beats, one per cycle and at most one valid at a time, starting the cycle after acceptance: invalidations, then forwards, then exactly one response beat. `req_ready_o` returns high in the cycle after the response beat.
- R3: A self-invalidating read (0) returns the stored value of every masked word and changes no sharer bit.
- R4: A shared read (1) returns the masked words like code 0 and also sets the requester's sharer bit on that line.
- R5: A write-through (2) stores the request's word data into every masked word, clears ownership of those words and is answered with an acknowledgement without data.
- R6: Take ownership (3) makes the requester the owner of every masked word and is answered without data. Take ownership with data (5) does the same and also returns the masked words' values from before the request.
- R7: Fetch-and-add (4) returns each masked word's old value, stores old + operand modulo 2^32 and clears ownership of those words.
- R8: A write-back (6) stores every masked word's data. It releases ownership only of masked words that the requester still owns, leaves words owned by other devices with their owner, and never causes an invalidation or a forward.
- R9: A request with code 2, 3, 4 or 5 on a line whose sharer vector holds devices other than the requester sends one invalidation per such device, in ascending device ID, ahead of any forward. All sharer bits of the line, including the requester's, are cleared afterwards.
- R10: Any request other than code 6 that masks a word owned by another device sends one forward per distinct owner, in ascending device ID. Each forward carries the opcode, the requester's ID, the line, and the mask of that owner's words inside the request mask. Forwards never go to the requester.
- R11: Word w of the write data and of the response data occupies bits [32w+31:32w], and mask bit w selects word w. `resp_has_data_o` is high for codes 0, 1, 4, 5 and 7. Unmasked words, and all words of a response without data, read zero.
- R12: Code 7 behaves exactly like code 0, and its forwards report opcode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle and able to accept a request |
| req_op_i | input | 3 | Request opcode |
| req_id_i | input | 2 | Requesting device ID |
| req_line_i | input | 4 | Line address |
| req_mask_i | input | 4 | Per-word mask |
| req_data_i | input | 128 | Per-word write data or fetch-and-add operands |
| inv_valid_o | output | 1 | Invalidation beat valid |
| inv_dev_o | output | 2 | Device to invalidate |
| inv_line_o | output | 4 | Line to invalidate |
| fwd_valid_o | output | 1 | Forward beat valid |
| fwd_dev_o | output | 2 | Current owner that receives the forward |
| fwd_src_o | output | 2 | Requester on whose behalf the request is forwarded |
| fwd_op_o | output | 3 | Forwarded opcode |
| fwd_line_o | output | 4 | Forwarded line |
| fwd_mask_o | output | 4 | Words held by the receiving owner within the request mask |
| resp_valid_o | output | 1 | Response beat valid |
| resp_id_o | output | 2 | Requester the response is addressed to |
| resp_has_data_o | output | 1 | Response carries data |
| resp_data_o | output | 128 | Response word data |

## Verification
The in-RTL assertions check, on every cycle, the properties that can be stated without knowing the stored contents:
- At most one kind of beat is valid at a time.
- The handshake locks out new requests while one is in progress and frees up after the response.
- No invalidation or forward is sent to the requester itself.
- A response without data carries zeros.

Only the bench's scenarios and its per-cycle reference model can show the remaining behaviour:
- The stored values, including fetch-and-add wrap-around.
- Ownership changes caused by take, write-through and write-back.
- The exact set and ascending order of invalidation and forward targets.
- The data returned after mixed sequences of requests.

// File: rtl/hyb_llc_pkg.sv
package hyb_llc_pkg;

  typedef enum logic [2:0] {
    OP_RD_SELF = 3'd0,
    OP_RD_SHR  = 3'd1,
    OP_WR_THRU = 3'd2,
    OP_TAKE    = 3'd3,
    OP_FADD    = 3'd4,
    OP_TAKE_RD = 3'd5,
    OP_EVICT   = 3'd6
  } op_e;

  typedef enum logic [1:0] {ST_IDLE, ST_INV, ST_FWD, ST_RESP} st_e;

  // code 7 folds onto the self-invalidating read
  function automatic op_e decode_op(input logic [2:0] code);
    case (code)
      3'd1:    return OP_RD_SHR;
      3'd2:    return OP_WR_THRU;
      3'd3:    return OP_TAKE;
      3'd4:    return OP_FADD;
      3'd5:    return OP_TAKE_RD;
      3'd6:    return OP_EVICT;
      default: return OP_RD_SELF;
    endcase
  endfunction

  function automatic logic op_writes(input op_e op);
    return op inside {OP_WR_THRU, OP_TAKE, OP_FADD, OP_TAKE_RD};
  endfunction

  function automatic logic op_returns(input op_e op);
    return op inside {OP_RD_SELF, OP_RD_SHR, OP_FADD, OP_TAKE_RD};
  endfunction

endpackage

// File: rtl/hyb_llc_pick.sv
module hyb_llc_pick #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec_i,
  output logic [W-1:0] idx_o,
  output logic [N-1:0] hot_o
);
  // lowest set bit wins
  always_comb begin
    idx_o = '0;
    hot_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o    = W'(i);
        hot_o    = '0;
        hot_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hyb_llc_dir.sv
module hyb_llc_dir
  import hyb_llc_pkg::*;
#(
  parameter int N_DEV  = 4,
  parameter int N_LINE = 16,
  parameter int N_WORD = 4,
  localparam int DEV_W  = (N_DEV > 1) ? $clog2(N_DEV) : 1,
  localparam int LINE_W = (N_LINE > 1) ? $clog2(N_LINE) : 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [LINE_W-1:0]                rd_line_i,
  output logic [N_WORD-1:0]                own_o,
  output logic [N_WORD-1:0][DEV_W-1:0]     owner_o,
  output logic [N_DEV-1:0]                 shr_o,
  input  logic                             upd_en_i,
  input  op_e                              upd_op_i,
  input  logic [DEV_W-1:0]                 upd_id_i,
  input  logic [LINE_W-1:0]                upd_line_i,
  input  logic [N_WORD-1:0]                upd_mask_i
);
  logic [N_DEV-1:0] shr_q [N_LINE];

  for (genvar w = 0; w < N_WORD; w++) begin : g_word
    logic             own_q   [N_LINE];
    logic [DEV_W-1:0] owner_q [N_LINE];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int l = 0; l < N_LINE; l++) begin
          own_q[l]   <= 1'b0;
          owner_q[l] <= '0;
        end
      end else if (upd_en_i && upd_mask_i[w]) begin
        case (upd_op_i)
          OP_TAKE, OP_TAKE_RD: begin
            own_q[upd_line_i]   <= 1'b1;
            owner_q[upd_line_i] <= upd_id_i;
          end
          OP_WR_THRU, OP_FADD: own_q[upd_line_i] <= 1'b0;
          OP_EVICT: if (owner_q[upd_line_i] == upd_id_i) own_q[upd_line_i] <= 1'b0;
          default: ;
        endcase
      end
    end

    assign own_o[w]   = own_q[rd_line_i];
    assign owner_o[w] = owner_q[rd_line_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int l = 0; l < N_LINE; l++) shr_q[l] <= '0;
    end else if (upd_en_i) begin
      if (op_writes(upd_op_i)) shr_q[upd_line_i] <= '0;
      else if (upd_op_i == OP_RD_SHR) shr_q[upd_line_i][upd_id_i] <= 1'b1;
    end
  end

  assign shr_o = shr_q[rd_line_i];
endmodule

// File: rtl/hyb_llc_data.sv
module hyb_llc_data
  import hyb_llc_pkg::*;
#(
  parameter int N_LINE = 16,
  parameter int N_WORD = 4,
  parameter int WORD_W = 32,
  localparam int LINE_W = (N_LINE > 1) ? $clog2(N_LINE) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [LINE_W-1:0]             rd_line_i,
  output logic [N_WORD-1:0][WORD_W-1:0] rd_data_o,
  input  logic                          upd_en_i,
  input  op_e                           upd_op_i,
  input  logic [LINE_W-1:0]             upd_line_i,
  input  logic [N_WORD-1:0]             upd_mask_i,
  input  logic [N_WORD-1:0][WORD_W-1:0] upd_data_i
);
  for (genvar w = 0; w < N_WORD; w++) begin : g_lane
    logic [WORD_W-1:0] mem_q [N_LINE];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int l = 0; l < N_LINE; l++) mem_q[l] <= '0;
      end else if (upd_en_i && upd_mask_i[w]) begin
        case (upd_op_i)
          OP_WR_THRU, OP_EVICT: mem_q[upd_line_i] <= upd_data_i[w];
          OP_FADD:              mem_q[upd_line_i] <= mem_q[upd_line_i] + upd_data_i[w];
          default: ;
        endcase
      end
    end

    assign rd_data_o[w] = mem_q[rd_line_i];
  end
endmodule

// File: rtl/hyb_llc_ctrl.sv
module hyb_llc_ctrl
  import hyb_llc_pkg::*;
#(
  parameter int N_DEV  = 4,
  parameter int N_LINE = 16,
  parameter int N_WORD = 4,
  parameter int WORD_W = 32,
  localparam int DEV_W  = (N_DEV > 1) ? $clog2(N_DEV) : 1,
  localparam int LINE_W = (N_LINE > 1) ? $clog2(N_LINE) : 1,
  localparam int DATA_W = N_WORD * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_op_i,
  input  logic [DEV_W-1:0]  req_id_i,
  input  logic [LINE_W-1:0] req_line_i,
  input  logic [N_WORD-1:0] req_mask_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              inv_valid_o,
  output logic [DEV_W-1:0]  inv_dev_o,
  output logic [LINE_W-1:0] inv_line_o,
  output logic              fwd_valid_o,
  output logic [DEV_W-1:0]  fwd_dev_o,
  output logic [DEV_W-1:0]  fwd_src_o,
  output logic [2:0]        fwd_op_o,
  output logic [LINE_W-1:0] fwd_line_o,
  output logic [N_WORD-1:0] fwd_mask_o,
  output logic              resp_valid_o,
  output logic [DEV_W-1:0]  resp_id_o,
  output logic              resp_has_data_o,
  output logic [DATA_W-1:0] resp_data_o
);
  st_e                           state_q;
  op_e                           c_op_q;
  logic [DEV_W-1:0]              c_id_q;
  logic [LINE_W-1:0]             c_line_q;
  logic [N_WORD-1:0]             c_mask_q;
  logic [N_WORD-1:0][WORD_W-1:0] c_data_q;
  logic [N_DEV-1:0]              inv_q, fwd_q;

  logic [LINE_W-1:0]             rd_line;
  logic [N_WORD-1:0]             own_w;
  logic [N_WORD-1:0][DEV_W-1:0]  owner_w;
  logic [N_DEV-1:0]              shr_w;
  logic [N_WORD-1:0][WORD_W-1:0] rd_data;
  logic [N_WORD-1:0][WORD_W-1:0] resp_words;

  op_e              in_op;
  logic [N_DEV-1:0] id_hot, inv_new, fwd_new;
  logic [N_DEV-1:0] inv_hot, fwd_hot, inv_rest, fwd_rest;
  logic [DEV_W-1:0] inv_idx, fwd_idx;
  logic             accept, upd_en;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign in_op       = decode_op(req_op_i);
  assign rd_line     = req_ready_o ? req_line_i : c_line_q;
  assign upd_en      = (state_q == ST_RESP);
  assign id_hot      = N_DEV'(1) << req_id_i;

  hyb_llc_dir #(.N_DEV(N_DEV), .N_LINE(N_LINE), .N_WORD(N_WORD)) u_dir (
    .clk_i, .rst_ni,
    .rd_line_i (rd_line),  .own_o(own_w), .owner_o(owner_w), .shr_o(shr_w),
    .upd_en_i  (upd_en),   .upd_op_i(c_op_q), .upd_id_i(c_id_q),
    .upd_line_i(c_line_q), .upd_mask_i(c_mask_q)
  );

  hyb_llc_data #(.N_LINE(N_LINE), .N_WORD(N_WORD), .WORD_W(WORD_W)) u_data (
    .clk_i, .rst_ni,
    .rd_line_i (rd_line), .rd_data_o(rd_data),
    .upd_en_i  (upd_en),  .upd_op_i(c_op_q), .upd_line_i(c_line_q),
    .upd_mask_i(c_mask_q), .upd_data_i(c_data_q)
  );

  hyb_llc_pick #(.N(N_DEV)) u_inv_pick (.vec_i(inv_q), .idx_o(inv_idx), .hot_o(inv_hot));
  hyb_llc_pick #(.N(N_DEV)) u_fwd_pick (.vec_i(fwd_q), .idx_o(fwd_idx), .hot_o(fwd_hot));

  assign inv_rest = inv_q & ~inv_hot;
  assign fwd_rest = fwd_q & ~fwd_hot;
  assign inv_new  = op_writes(in_op) ? (shr_w & ~id_hot) : '0;

  // owners other than the requester of any masked word
  always_comb begin
    fwd_new = '0;
    for (int w = 0; w < N_WORD; w++)
      if (req_mask_i[w] && own_w[w] && owner_w[w] != req_id_i && in_op != OP_EVICT)
        fwd_new[owner_w[w]] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      c_op_q   <= OP_RD_SELF;
      c_id_q   <= '0;
      c_line_q <= '0;
      c_mask_q <= '0;
      c_data_q <= '0;
      inv_q    <= '0;
      fwd_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          c_op_q   <= in_op;
          c_id_q   <= req_id_i;
          c_line_q <= req_line_i;
          c_mask_q <= req_mask_i;
          c_data_q <= req_data_i;
          inv_q    <= inv_new;
          fwd_q    <= fwd_new;
          state_q  <= (inv_new != '0) ? ST_INV : (fwd_new != '0) ? ST_FWD : ST_RESP;
        end
        ST_INV: begin
          inv_q <= inv_rest;
          if (inv_rest == '0) state_q <= (fwd_q != '0) ? ST_FWD : ST_RESP;
        end
        ST_FWD: begin
          fwd_q <= fwd_rest;
          if (fwd_rest == '0) state_q <= ST_RESP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    fwd_mask_o = '0;
    for (int w = 0; w < N_WORD; w++) begin
      fwd_mask_o[w] = c_mask_q[w] && own_w[w] && owner_w[w] == fwd_idx;
      resp_words[w] = (op_returns(c_op_q) && c_mask_q[w]) ? rd_data[w] : '0;
    end
  end

  assign inv_valid_o     = (state_q == ST_INV);
  assign inv_dev_o       = inv_idx;
  assign inv_line_o      = c_line_q;
  assign fwd_valid_o     = (state_q == ST_FWD);
  assign fwd_dev_o       = fwd_idx;
  assign fwd_src_o       = c_id_q;
  assign fwd_op_o        = c_op_q;
  assign fwd_line_o      = c_line_q;
  assign resp_valid_o    = upd_en;
  assign resp_id_o       = c_id_q;
  assign resp_has_data_o = op_returns(c_op_q);
  assign resp_data_o     = resp_words;

  // R2
  one_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({inv_valid_o, fwd_valid_o, resp_valid_o}));
  // R2
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  // R2
  ready_after_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> req_ready_o);
  // R9
  inv_not_self_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_o |-> inv_dev_o != resp_id_o);
  // R10
  fwd_not_self_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> (fwd_dev_o != fwd_src_o && fwd_mask_o != '0));
  // R11
  ack_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_has_data_o) |-> resp_data_o == '0);
endmodule

// File: tb/hyb_llc_ctrl_test.sv
module hyb_llc_ctrl_test;
  localparam int ND = 4, NL = 16, NW = 4, WW = 32, DW = NW * WW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_op = '0;
  logic [1:0]    req_id = '0;
  logic [3:0]    req_line = '0;
  logic [NW-1:0] req_mask = '0;
  logic [DW-1:0] req_data = '0;
  logic          inv_valid, fwd_valid, resp_valid, resp_has;
  logic [1:0]    inv_dev, fwd_dev, fwd_src, resp_id;
  logic [3:0]    inv_line, fwd_line;
  logic [2:0]    fwd_op;
  logic [NW-1:0] fwd_mask;
  logic [DW-1:0] resp_data;

  always #10 clk = ~clk;

  hyb_llc_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_id_i(req_id), .req_line_i(req_line), .req_mask_i(req_mask), .req_data_i(req_data),
    .inv_valid_o(inv_valid), .inv_dev_o(inv_dev), .inv_line_o(inv_line),
    .fwd_valid_o(fwd_valid), .fwd_dev_o(fwd_dev), .fwd_src_o(fwd_src), .fwd_op_o(fwd_op),
    .fwd_line_o(fwd_line), .fwd_mask_o(fwd_mask),
    .resp_valid_o(resp_valid), .resp_id_o(resp_id), .resp_has_data_o(resp_has),
    .resp_data_o(resp_data)
  );

  typedef struct {
    int            kind;  // 0 inv, 1 fwd, 2 resp
    int            dev;
    int            src;
    int            op;
    int            line;
    int            mask;
    bit            has;
    logic [DW-1:0] data;
    string         tag;
  } beat_t;

  beat_t         expq[$];
  logic [WW-1:0] md [NL][NW];
  bit            mo [NL][NW];
  int            mw [NL][NW];
  bit [ND-1:0]   ms [NL];
  int            n_chk = 0, n_fail = 0, cyc = 0;
  bit            running = 1'b0, done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [DW+15:0] act, input logic [DW+15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  // reference: expected beats of one accepted request, then model state update
  task automatic model_req(input int op, input int id, input int line, input int mask,
                           input logic [DW-1:0] data, input string tag);
    int o;
    bit wr;
    beat_t b;
    o  = (op == 7) ? 0 : op;
    wr = (o == 2 || o == 3 || o == 4 || o == 5);
    if (wr)
      for (int d = 0; d < ND; d++)
        if (ms[line][d] && d != id) begin
          b = '{kind:0, dev:d, src:0, op:0, line:line, mask:0, has:0, data:'0, tag:tag};
          expq.push_back(b);
        end
    if (o != 6)
      for (int d = 0; d < ND; d++) begin
        int fm = 0;
        for (int w = 0; w < NW; w++)
          if (mask[w] && mo[line][w] && mw[line][w] == d && d != id) fm |= (1 << w);
        if (fm != 0) begin
          b = '{kind:1, dev:d, src:id, op:o, line:line, mask:fm, has:0, data:'0, tag:tag};
          expq.push_back(b);
        end
      end
    b = '{kind:2, dev:0, src:id, op:o, line:line, mask:mask, has:0, data:'0, tag:tag};
    b.has = (o == 0 || o == 1 || o == 4 || o == 5);
    for (int w = 0; w < NW; w++)
      if (b.has && mask[w]) b.data[w*WW +: WW] = md[line][w];
    expq.push_back(b);
    if (wr) ms[line] = '0;
    else if (o == 1) ms[line][id] = 1'b1;
    for (int w = 0; w < NW; w++) begin
      if (mask[w]) begin
        case (o)
          2: begin md[line][w] = data[w*WW +: WW]; mo[line][w] = 0; end
          3, 5: begin mo[line][w] = 1; mw[line][w] = id; end
          4: begin md[line][w] = md[line][w] + data[w*WW +: WW]; mo[line][w] = 0; end
          6: begin
            md[line][w] = data[w*WW +: WW];
            if (mo[line][w] && mw[line][w] == id) mo[line][w] = 0;
          end
          default: ;
        endcase
      end
    end
  endtask

  task automatic issue(input int op, input int id, input int line, input int mask,
                       input logic [DW-1:0] data, input string tag);
    @(posedge clk); #2;
    while (!req_ready) begin @(posedge clk); #2; end
    req_valid = 1'b1;
    req_op    = 3'(op);
    req_id    = 2'(id);
    req_line  = 4'(line);
    req_mask  = 4'(mask);
    req_data  = data;
    @(posedge clk); #1;
    model_req(op, id, line, mask, data, tag);
    req_valid = 1'b0;
  endtask

  function automatic logic [DW-1:0] words(input logic [WW-1:0] w3, input logic [WW-1:0] w2,
                                          input logic [WW-1:0] w1, input logic [WW-1:0] w0);
    return {w3, w2, w1, w0};
  endfunction

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (running && !done) begin
      if (expq.size() > 0) begin
        beat_t b;
        b = expq.pop_front();
        check(!req_ready, b.tag, "ready during beats", DW'(req_ready), '0);
        case (b.kind)
          0: check({inv_valid, fwd_valid, resp_valid} == 3'b100 && inv_dev == 2'(b.dev)
                   && inv_line == 4'(b.line), b.tag, "invalidate",
                   {inv_valid, fwd_valid, resp_valid, inv_dev, inv_line},
                   {3'b100, 2'(b.dev), 4'(b.line)});
          1: check({inv_valid, fwd_valid, resp_valid} == 3'b010 && fwd_dev == 2'(b.dev)
                   && fwd_src == 2'(b.src) && fwd_op == 3'(b.op) && fwd_line == 4'(b.line)
                   && fwd_mask == 4'(b.mask), b.tag, "forward",
                   {inv_valid, fwd_valid, resp_valid, fwd_dev, fwd_src, fwd_op, fwd_line, fwd_mask},
                   {3'b010, 2'(b.dev), 2'(b.src), 3'(b.op), 4'(b.line), 4'(b.mask)});
          default: check({inv_valid, fwd_valid, resp_valid} == 3'b001 && resp_id == 2'(b.src)
                   && resp_has == b.has && resp_data == b.data, b.tag, "response",
                   {inv_valid, fwd_valid, resp_valid, resp_id, resp_has, resp_data},
                   {3'b001, 2'(b.src), b.has, b.data});
        endcase
      end else begin
        check({inv_valid, fwd_valid, resp_valid, req_ready} == 4'b0001, "R2", "idle outputs",
              {inv_valid, fwd_valid, resp_valid, req_ready}, 4'b0001);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  initial begin
    for (int l = 0; l < NL; l++) begin
      ms[l] = '0;
      for (int w = 0; w < NW; w++) begin md[l][w] = '0; mo[l][w] = 0; mw[l][w] = 0; end
    end
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check(req_ready && !inv_valid && !fwd_valid && !resp_valid, "R1", "reset outputs",
          {req_ready, inv_valid, fwd_valid, resp_valid}, 4'b1000);
    running = 1'b1;

    issue(0, 0, 3, 4'hF, '0, "R1");
    issue(2, 1, 3, 4'b0101, words(32'h4, 32'hC0DE_0002, 32'h2, 32'hC0DE_0000), "R5");
    issue(0, 2, 3, 4'hF, '0, "R3");
    issue(0, 2, 3, 4'b0100, '0, "R11");
    issue(1, 1, 3, 4'hF, '0, "R4");
    issue(1, 2, 3, 4'b0001, '0, "R4");
    issue(0, 3, 3, 4'hF, '0, "R3");
    issue(2, 0, 3, 4'b0010, words(0, 0, 32'h1111_1111, 0), "R9");
    issue(1, 0, 3, 4'hF, '0, "R4");
    issue(1, 2, 3, 4'hF, '0, "R4");
    issue(2, 2, 3, 4'b1000, words(32'h7777_0000, 0, 0, 0), "R9");
    issue(2, 1, 3, 4'b1000, words(32'h7777_0001, 0, 0, 0), "R9");

    issue(3, 1, 5, 4'b0011, '0, "R6");
    issue(0, 2, 5, 4'hF, '0, "R10");
    issue(5, 3, 5, 4'b0110, '0, "R6");
    issue(0, 0, 5, 4'hF, '0, "R10");
    issue(7, 0, 5, 4'hF, '0, "R12");
    issue(2, 2, 5, 4'b0001, words(0, 0, 0, 32'hABCD), "R5");
    issue(0, 0, 5, 4'hF, '0, "R5");

    issue(2, 0, 7, 4'b0011, words(0, 0, 32'h10, 32'hFFFF_FFFF), "R7");
    issue(4, 0, 7, 4'b0011, words(0, 0, 32'h5, 32'h2), "R7");
    issue(4, 1, 7, 4'b1001, words(32'h9, 0, 0, 32'h3), "R7");
    issue(0, 2, 7, 4'hF, '0, "R7");

    issue(3, 1, 9, 4'b1100, '0, "R8");
    issue(1, 3, 9, 4'hF, '0, "R8");
    issue(6, 2, 9, 4'hF, words(32'hD3, 32'hD2, 32'hD1, 32'hD0), "R8");
    issue(0, 0, 9, 4'hF, '0, "R8");
    issue(6, 1, 9, 4'b0100, words(0, 32'hE2, 0, 0), "R8");
    issue(0, 0, 9, 4'hF, '0, "R8");
    issue(7, 3, 9, 4'b1010, '0, "R12");

    for (int i = 0; i < 400; i++)
      issue($urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 3),
            $urandom_range(0, 15), {$urandom, $urandom, $urandom, $urandom}, "R2");

    repeat (20) @(posedge clk);
    finish_run();
  end
endmodule